// File: doc/BRIEF.md
# Serial Sample Port with Frame Generator

This block is the input side of one transmit channel. It is the timing master of a three-wire serial link: it divides the master clock down to a serial clock, and it emits a frame pulse once per input sample period. It then shifts in one 32-bit quadrature word per frame and hands it to the downstream filter as parallel 16-bit I and Q values with a one-cycle strobe in the master clock domain.

The sample period is a programmable number of master clocks (the channel's total interpolation factor). This count need not be a whole number of serial clocks. The frame generator therefore places each frame on the serial clock edge that first reaches or passes the ideal sample instant. This makes consecutive frame spacings differ by one serial clock while the long-run frame rate stays exactly fCLK/L. No divider is needed: a phase accumulator adds the serial clock period on each serial edge and takes off L whenever a frame is issued.

A channel reset stops the serial clock low and rearms the frame generator. A sleep input holds the frame pulse low, so that no new words are requested.

Top module: `iq_serial_port`

## Requirements
- R1: The serial clock `sclk` has a period of P = 2*(`div`+1) master clocks with equal high and low halves, where `div` is a 5-bit unsigned value (0 to 31).
- R2: `sclk` is low while `rst` or `chan_rst` is high. The first master clock edge after both are low drives `sclk` high.
- R3: The frame pulse `sfs` rises on the same master edge as a rising edge of `sclk` and stays high for exactly one serial clock period (P master clocks).
- R4: Measured from the first frame, frame k begins P*ceil(k*L/P) master clocks later, where L is `interp`. Consecutive spacings are therefore exactly L when P divides L, and otherwise alternate between the two neighbouring multiples of P. L must be at least 34*P.
- R5: No frame pulse begins while `sleep` is high. Frames resume after `sleep` returns low.
- R6: A word is received MSB first. Its first 16 bits appear on `i_out` (first bit in `i_out[15]`) and the next 16 bits appear on `q_out` (last bit in `q_out[0]`).
- R7: The first data bit is sampled on the second rising `sclk` edge after the one that raised `sfs`. Each bit is taken at the master edge where `sclk` goes high, from the value `sdin` held before that edge.
- R8: After the 32nd bit, further `sclk` edges are ignored until the next frame. They produce no `iq_valid`, and `i_out`/`q_out` do not change.
- R9: `iq_valid` is high for exactly one master cycle, on the edge that samples the 32nd bit (the 33rd `sclk` rise after the frame). `i_out` and `q_out` take the new word on that same edge.
- R10: The first frame after a reset release coincides with the first rising edge of `sclk`.
- R11: After `rst`, `sclk`, `sfs`, `iq_valid`, `i_out` and `q_out` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high block reset |
| chan_rst | input | 1 | Channel reset: holds the serial clock low and rearms framing |
| sleep | input | 1 | Suppresses frame pulses while high |
| div | input | 5 | Serial clock divider value |
| interp | input | 16 | Input sample period L in master clocks |
| sdin | input | 1 | Serial data input |
| sclk | output | 1 | Generated serial clock |
| sfs | output | 1 | Frame pulse, one serial clock long |
| i_out | output | 16 | Received in-phase sample |
| q_out | output | 16 | Received quadrature sample |
| iq_valid | output | 1 | One-cycle strobe for new I/Q data |

## Verification
The embedded properties check the following on every cycle:
- the serial clock stays low in reset and starts on the first edge after release;
- a frame only rises on a serial rising edge and only falls at the next one;
- no frame starts out of sleep;
- the valid strobe is a single cycle tied to a serial edge, with the shifter idle afterwards.

The exact frame spacing sequence for fractional ratios, the bit order and alignment of the captured word, the serial clock period, and the resumption after sleep can only be shown by the bench's scenarios. The bench compares these against values it computes from the divider and interpolation settings.

// File: rtl/sps_pkg.sv
package sps_pkg;

    localparam int SAMPLE_W = 16;
    localparam int WORD_W   = 2 * SAMPLE_W;
    // the shifter position runs 0 (idle), 1 (skip edge), 2..WORD_W+1 (capture)
    localparam int LAST_POS = WORD_W + 1;
    localparam int POS_W    = $clog2(LAST_POS + 1);

    typedef struct packed {
        logic [SAMPLE_W-1:0] i;
        logic [SAMPLE_W-1:0] q;
    } iq_word_t;

    // master clocks per serial clock period
    function automatic int unsigned sclk_period(input int unsigned div_val);
        return 2 * (div_val + 1);
    endfunction

endpackage

// File: rtl/sps_clkgen.sv
module sps_clkgen #(
    parameter int DIV_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             chan_rst,
    input  logic [DIV_W-1:0] div,
    output logic             sclk,
    output logic             rise_evt
);
    logic [DIV_W-1:0] cnt;
    logic             stop;
    logic             tick;

    assign stop     = rst | chan_rst;
    assign tick     = (cnt >= div);
    assign rise_evt = ~stop & tick & ~sclk;

    always_ff @(posedge clk) begin
        if (stop) begin
            cnt  <= div;          // next edge after release toggles at once
            sclk <= 1'b0;
        end else if (tick) begin
            cnt  <= '0;
            sclk <= ~sclk;
        end else begin
            cnt  <= cnt + DIV_W'(1);
        end
    end

    p_sclk_low_r2: assert property (@(posedge clk) disable iff (rst)
        chan_rst |=> !sclk);

    p_sclk_start_r2: assert property (@(posedge clk) disable iff (rst)
        (!chan_rst && $past(chan_rst)) |=> sclk);

endmodule

// File: rtl/sps_framer.sv
module sps_framer
    import sps_pkg::*;
#(
    parameter int DIV_W = 5,
    parameter int L_W   = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             chan_rst,
    input  logic             sleep,
    input  logic [DIV_W-1:0] div,
    input  logic [L_W-1:0]   interp,
    input  logic             rise_evt,
    output logic             sfs,
    output logic             frame_evt
);
    localparam int ACC_W = L_W + 1;

    logic [ACC_W-1:0] acc;
    logic [ACC_W-1:0] step;
    logic [ACC_W-1:0] sum;
    logic [ACC_W-1:0] limit;
    logic             hit;

    assign step      = ACC_W'(sclk_period(int'(div)));
    assign limit     = {1'b0, interp};
    assign sum       = acc + step;
    assign hit       = (sum >= limit);
    assign frame_evt = rise_evt & hit & ~sleep;

    always_ff @(posedge clk) begin
        if (rst | chan_rst) begin
            acc <= limit - step;  // first serial edge issues a frame
            sfs <= 1'b0;
        end else if (rise_evt) begin
            acc <= hit ? (sum - limit) : sum;
            sfs <= hit & ~sleep;
        end
    end

    p_no_frame_in_sleep_r5: assert property (@(posedge clk) disable iff (rst | chan_rst)
        $rose(sfs) |-> !$past(sleep));

    p_frame_one_period_r3: assert property (@(posedge clk) disable iff (rst | chan_rst)
        $fell(sfs) |-> $past(rise_evt));

endmodule

// File: rtl/sps_shifter.sv
module sps_shifter
    import sps_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     chan_rst,
    input  logic     rise_evt,
    input  logic     frame_evt,
    input  logic     sdin,
    output iq_word_t word,
    output logic     valid
);
    logic [POS_W-1:0]  pos;
    logic [WORD_W-2:0] shreg;

    always_ff @(posedge clk) begin
        if (rst) begin
            word <= '0;
        end
        if (rst | chan_rst) begin
            pos   <= '0;
            shreg <= '0;
            valid <= 1'b0;
        end else begin
            valid <= 1'b0;
            if (frame_evt) begin
                pos <= POS_W'(1);
            end else if (rise_evt && pos != '0) begin
                if (pos >= POS_W'(2)) begin
                    shreg <= {shreg[WORD_W-3:0], sdin};
                end
                if (pos == POS_W'(LAST_POS)) begin
                    word  <= {shreg, sdin};
                    valid <= 1'b1;
                    pos   <= '0;
                end else begin
                    pos <= pos + POS_W'(1);
                end
            end
        end
    end

    p_valid_single_r9: assert property (@(posedge clk) disable iff (rst | chan_rst)
        valid |=> !valid);

    p_valid_on_edge_r9: assert property (@(posedge clk) disable iff (rst | chan_rst)
        valid |-> $past(rise_evt));

    p_idle_after_word_r8: assert property (@(posedge clk) disable iff (rst | chan_rst)
        valid |-> (pos == '0));

endmodule

// File: rtl/iq_serial_port.sv
module iq_serial_port
    import sps_pkg::*;
#(
    parameter int DIV_W = 5,
    parameter int L_W   = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                chan_rst,
    input  logic                sleep,
    input  logic [DIV_W-1:0]    div,
    input  logic [L_W-1:0]      interp,
    input  logic                sdin,
    output logic                sclk,
    output logic                sfs,
    output logic [SAMPLE_W-1:0] i_out,
    output logic [SAMPLE_W-1:0] q_out,
    output logic                iq_valid
);
    logic     rise_evt;
    logic     frame_evt;
    iq_word_t word;

    sps_clkgen #(.DIV_W(DIV_W)) u_clkgen (
        .clk      (clk),
        .rst      (rst),
        .chan_rst (chan_rst),
        .div      (div),
        .sclk     (sclk),
        .rise_evt (rise_evt)
    );

    sps_framer #(.DIV_W(DIV_W), .L_W(L_W)) u_framer (
        .clk       (clk),
        .rst       (rst),
        .chan_rst  (chan_rst),
        .sleep     (sleep),
        .div       (div),
        .interp    (interp),
        .rise_evt  (rise_evt),
        .sfs       (sfs),
        .frame_evt (frame_evt)
    );

    sps_shifter u_shifter (
        .clk       (clk),
        .rst       (rst),
        .chan_rst  (chan_rst),
        .rise_evt  (rise_evt),
        .frame_evt (frame_evt),
        .sdin      (sdin),
        .word      (word),
        .valid     (iq_valid)
    );

    assign i_out = word.i;
    assign q_out = word.q;

    p_frame_on_sclk_rise_r3: assert property (@(posedge clk) disable iff (rst | chan_rst)
        $rose(sfs) |-> $rose(sclk));

endmodule

// File: tb/iq_serial_port_test.sv
module iq_serial_port_test;

    typedef struct packed {
        logic [4:0]  dv;
        logic [15:0] len;
        logic [31:0] word;
    } vec_t;

    localparam int NVEC = 4;
    localparam vec_t VECS [NVEC] = '{
        '{5'd0, 16'd80,  32'h1234ABCD},   // P=2, integer ratio
        '{5'd1, 16'd138, 32'h80007FFF},   // P=4, 34.5 serial clocks
        '{5'd3, 16'd300, 32'hFFFF0001},   // P=8, 37.5 serial clocks
        '{5'd2, 16'd220, 32'h5A5AC3C3}    // P=6, 36.67 serial clocks
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        chan_rst = 1'b1;
    logic        sleep = 1'b0;
    logic [4:0]  div = 5'd0;
    logic [15:0] interp = 16'd80;
    logic        sdin = 1'b0;
    logic        sclk;
    logic        sfs;
    logic [15:0] i_out;
    logic [15:0] q_out;
    logic        iq_valid;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    iq_serial_port uut (
        .clk(clk), .rst(rst), .chan_rst(chan_rst), .sleep(sleep),
        .div(div), .interp(interp), .sdin(sdin),
        .sclk(sclk), .sfs(sfs), .i_out(i_out), .q_out(q_out), .iq_valid(iq_valid)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int cdiv(input int a, input int b);
        return (a + b - 1) / b;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    task automatic run_vector(input vec_t v);
        int p;
        int len;
        int cyc = 0;
        int nf = 0;
        int nv = 0;
        int rc = 0;
        int bad_t = 0;
        int bad_d = 0;
        int bad_s = 0;
        int first_rise = -1;
        int second_rise = -1;
        int sfs_fall = -1;
        int ft [9];
        bit ps = 1'b0;
        bit pf = 1'b0;
        bit pv = 1'b0;
        bit first_ok;
        p   = 2 * (int'(v.dv) + 1);
        len = int'(v.len);
        chan_rst = 1'b1;
        div      = v.dv;
        interp   = v.len;
        repeat (3) @(negedge clk);
        chan_rst = 1'b0;
        @(negedge clk);
        // R2 and R10: sclk and sfs both high after the first edge
        first_ok = sclk && sfs;
        check(sclk === 1'b1, "R2 sclk high after release", int'(sclk), 1);
        check(sfs === 1'b1, "R10 first frame at first sclk rise", int'(sfs), 1);
        while (nf < 9 && cyc < 40 * len) begin
            if (cyc > 0) @(negedge clk);
            if (sclk && !ps) begin
                if (first_rise < 0) first_rise = cyc;
                else if (second_rise < 0) second_rise = cyc;
            end
            if (sfs && !pf) begin
                if (!(sclk && !ps)) bad_s++;
                ft[nf] = cyc;
                nf++;
                rc = 0;
            end else if (sclk && !ps) begin
                rc++;
            end
            if (!sfs && pf && sfs_fall < 0) sfs_fall = cyc;
            if (!sclk && ps) begin
                if (rc >= 1 && rc <= 32) sdin = v.word[32 - rc];
                else sdin = cyc[1];       // junk outside the word
            end
            if (iq_valid) begin
                nv++;
                if (pv || rc != 33) bad_t++;
                if ({i_out, q_out} !== v.word) bad_d++;
            end else if (nv > 0 && {i_out, q_out} !== v.word) begin
                bad_d++;                  // R8: outputs hold between words
            end
            ps = sclk;
            pf = sfs;
            pv = iq_valid;
            cyc++;
        end
        check(first_ok, "R10 frame and clock start together", int'(first_ok), 1);
        check(second_rise - first_rise == p, "R1 sclk period", second_rise - first_rise, p);
        check(sfs_fall - ft[0] == p, "R3 sfs width one sclk period", sfs_fall - ft[0], p);
        check(bad_s == 0, "R3 sfs rises with sclk", bad_s, 0);
        check(nf == 9, "R4 frame count", nf, 9);
        for (int k = 1; k < 9; k++) begin
            int exp_sp;
            exp_sp = p * (cdiv(k * len, p) - cdiv((k - 1) * len, p));
            check(ft[k] - ft[k-1] == exp_sp, $sformatf("R4 spacing %0d", k),
                  ft[k] - ft[k-1], exp_sp);
        end
        check(ft[8] - ft[0] == p * cdiv(8 * len, p), "R4 long-run position",
              ft[8] - ft[0], p * cdiv(8 * len, p));
        check(nv == 8, "R8 one valid per frame", nv, 8);
        check(bad_t == 0, "R9 valid timing and width", bad_t, 0);
        check(bad_d == 0, "R6 R7 word data", bad_d, 0);
        check(i_out == v.word[31:16], "R6 i_out", int'(i_out), int'(v.word[31:16]));
        check(q_out == v.word[15:0], "R6 q_out", int'(q_out), int'(v.word[15:0]));
    endtask

    initial begin
        int seen_sfs;
        int seen_v;
        int wait_c;
        repeat (3) @(negedge clk);
        // R11: reset state
        check(sclk === 1'b0, "R11 sclk reset", int'(sclk), 0);
        check(sfs === 1'b0, "R11 sfs reset", int'(sfs), 0);
        check(iq_valid === 1'b0, "R11 valid reset", int'(iq_valid), 0);
        check(i_out === 16'd0, "R11 i_out reset", int'(i_out), 0);
        check(q_out === 16'd0, "R11 q_out reset", int'(q_out), 0);
        rst = 1'b0;
        // R2: serial clock held low during channel reset
        seen_sfs = 0;
        for (int c = 0; c < 20; c++) begin
            @(negedge clk);
            if (sclk || sfs) seen_sfs++;
        end
        check(seen_sfs == 0, "R2 sclk low in channel reset", seen_sfs, 0);

        // vector table
        for (int n = 0; n < NVEC; n++) run_vector(VECS[n]);

        // R5: sleep suppresses frames
        run_vector(VECS[0]);
        sleep = 1'b1;
        repeat (100) @(negedge clk);
        seen_sfs = 0;
        seen_v = 0;
        for (int c = 0; c < 300; c++) begin
            @(negedge clk);
            if (sfs) seen_sfs++;
            if (iq_valid) seen_v++;
        end
        check(seen_sfs == 0, "R5 no frame in sleep", seen_sfs, 0);
        check(seen_v == 0, "R5 no word in sleep", seen_v, 0);
        sleep = 1'b0;
        wait_c = 0;
        while (!sfs && wait_c < 200) begin
            @(negedge clk);
            wait_c++;
        end
        check(sfs === 1'b1 && wait_c <= 82, "R5 frames resume after sleep", wait_c, 82);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule